// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of an on-chip scratchpad built from 32 independent single-port banks, each one 32-bit word wide. It takes one warp-wide request at a time. A request holds 32 lanes, and each lane has an enable, a byte address, a write flag and write data. The block works out which bank every lane targets. Lanes that touch distinct words of the same bank cannot share a cycle, so it replays the request over as many passes as the worst bank needs. In each pass every bank performs at most one access.

Lanes that name the same word share a single access. Reads are broadcast to all of them, and among several writers to one word the highest-numbered lane decides the stored value. Once the last pass is done, the block pulses a completion flag and presents two results: the per-lane read data and the conflict degree, which is the number of passes used. While passes remain, the block refuses new work through a ready/valid handshake.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A lane's word address is its byte address shifted right by 2, so the two low byte bits are ignored. The bank is bits [6:2] of the byte address and the row inside the bank is bits [12:7].
- R2: Any number of active lanes that name the same word are served in one pass. Such a group counts as one word toward the conflict degree.
- R3: The conflict degree D is the largest number of distinct words that the active lanes place in any single bank. done_o is first high in the cycle after the D-th rising edge that follows the accepting edge, and degree_o equals D in that cycle.
- R4: A request is taken on a rising edge where req_valid_i and req_ready_o are both high. req_ready_o is low from the cycle after accepting a request with D>=1 up to its done cycle, and it is high in the done cycle.
- R5: Word strides of 1, 2, 4 and 32 across the 32 lanes give degrees of 1, 2, 4 and 32.
- R6: In the done cycle, each active lane's field of rdata_o (bits [32*l+31:32*l]) holds the content its word had before the request. The field of an inactive lane is zero. rdata_o holds its value until the next request is accepted.
- R7: When several active lanes of one request write the same word, the word keeps the data of the highest-numbered writer. Words that only active readers touch are left unchanged.
- R8: Inactive lanes write nothing and add nothing to the degree. A request with no active lane raises done_o in the cycle after the accepting edge, with degree 0.
- R9: After reset, req_ready_o is high, done_o is low, and degree_o and rdata_o are zero.
- R10: done_o is high for exactly one cycle per request, unless a new request is accepted in that cycle and finishes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is offered |
| req_ready_o | output | 1 | The block can accept a request |
| lane_valid_i | input | 32 | Per-lane active flag |
| lane_addr_i | input | 416 | Per-lane byte address, 13 bits per lane, lane l at [13l+12:13l] |
| lane_we_i | input | 32 | Per-lane write flag |
| lane_wdata_i | input | 1024 | Per-lane write data, 32 bits per lane |
| done_o | output | 1 | One-cycle completion pulse |
| degree_o | output | 6 | Number of passes used by the last finished request |
| rdata_o | output | 1024 | Per-lane returned word, 32 bits per lane |

## Verification
Two events can land in the same cycle: the completion of one request (done_o, degree_o and rdata_o being valid) and the acceptance of the next one. The bench provokes this on every back-to-back request by presenting the next request during the done cycle. It then judges both at once. It checks the finished request's degree, its read data and the high level of req_ready_o. It checks the new request by timing its own completion and by comparing its read data against a model that has already applied the previous request's writes, including the highest-lane-wins rule.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
  localparam int unsigned SCS_LANES  = 32;
  localparam int unsigned SCS_BANKS  = 32;
  localparam int unsigned SCS_ROW_W  = 6;
  localparam int unsigned SCS_DATA_W = 32;
  localparam int unsigned SCS_BYTE_W = 2;
endpackage

// File: rtl/scs_bank_pick.sv
`timescale 1ns/1ps
// Per-bank selection: lowest pending lane picks the word, all lanes on that word ride along.
module scs_bank_pick #(
  parameter int unsigned NUM_LANES = 32,
  parameter int unsigned ROW_W     = 6,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_LANES-1:0]                  hit_i,
  input  logic [NUM_LANES-1:0][ROW_W-1:0]       row_i,
  input  logic [NUM_LANES-1:0]                  we_i,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]      wdata_i,
  output logic [NUM_LANES-1:0]                  serve_o,
  output logic [ROW_W-1:0]                      row_o,
  output logic                                  wr_o,
  output logic [DATA_W-1:0]                     wdata_o
);
  logic            act;
  logic [ROW_W-1:0] sel_row;

  always_comb begin
    act     = 1'b0;
    sel_row = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (hit_i[l] && !act) begin
        act     = 1'b1;
        sel_row = row_i[l];
      end
    end
  end

  // ascending scan: highest-numbered writer overrides
  always_comb begin
    serve_o = '0;
    wr_o    = 1'b0;
    wdata_o = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (hit_i[l] && row_i[l] == sel_row) begin
        serve_o[l] = 1'b1;
        if (we_i[l]) begin
          wr_o    = 1'b1;
          wdata_o = wdata_i[l];
        end
      end
    end
  end

  assign row_o = sel_row;

  AST_SERVE_IN_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serve_o & ~hit_i) == '0); // R2
  AST_LOWEST_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |-> ((serve_o & hit_i & (~hit_i + NUM_LANES'(1))) != '0)); // R2
endmodule

// File: rtl/scs_bank_ram.sv
`timescale 1ns/1ps
module scs_bank_ram #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[row_i] <= wdata_i;
  end

  // read returns the pre-pass content; write lands at the edge
  assign rdata_o = mem[row_i];
endmodule

// File: rtl/bank_conflict_serializer.sv
`timescale 1ns/1ps
module bank_conflict_serializer
  import scs_pkg::*;
#(
  parameter int unsigned NUM_LANES = SCS_LANES,
  parameter int unsigned NUM_BANKS = SCS_BANKS,
  parameter int unsigned ROW_W     = SCS_ROW_W,
  parameter int unsigned DATA_W    = SCS_DATA_W,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned ADDR_W   = SCS_BYTE_W + BANK_W + ROW_W,
  localparam int unsigned DEG_W    = $clog2(NUM_LANES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [NUM_LANES-1:0]          lane_valid_i,
  input  logic [NUM_LANES*ADDR_W-1:0]   lane_addr_i,
  input  logic [NUM_LANES-1:0]          lane_we_i,
  input  logic [NUM_LANES*DATA_W-1:0]   lane_wdata_i,
  output logic                          done_o,
  output logic [DEG_W-1:0]              degree_o,
  output logic [NUM_LANES*DATA_W-1:0]   rdata_o
);
  logic [NUM_LANES-1:0]              pend_q;
  logic [NUM_LANES-1:0][BANK_W-1:0]  bank_q, bank_d;
  logic [NUM_LANES-1:0][ROW_W-1:0]   row_q, row_d;
  logic [NUM_LANES-1:0]              we_q;
  logic [NUM_LANES-1:0][DATA_W-1:0]  wdata_q, wdata_d;
  logic [NUM_LANES-1:0][DATA_W-1:0]  rdata_q;
  logic                              busy_q, done_q;
  logic [DEG_W-1:0]                  pass_q, degree_q;

  logic [NUM_BANKS-1:0][NUM_LANES-1:0] hit, bank_serve;
  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_rd;
  logic [NUM_LANES-1:0]                served, pend_nxt;
  logic [NUM_LANES-1:0][DATA_W-1:0]    lane_rd;
  logic [NUM_LANES*SCS_BYTE_W-1:0]     unused_byte_off;
  logic                                fire;

  assign req_ready_o = !busy_q;
  assign fire        = req_valid_i && req_ready_o;
  assign wdata_d     = lane_wdata_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_dec
    assign bank_d[l] = lane_addr_i[l*ADDR_W + SCS_BYTE_W +: BANK_W];
    assign row_d[l]  = lane_addr_i[l*ADDR_W + SCS_BYTE_W + BANK_W +: ROW_W];
    assign unused_byte_off[l*SCS_BYTE_W +: SCS_BYTE_W] = lane_addr_i[l*ADDR_W +: SCS_BYTE_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_hit
      assign hit[b][l] = pend_q[l] && (bank_q[l] == BANK_W'(b));
    end

    logic [ROW_W-1:0]  pick_row;
    logic              pick_wr;
    logic [DATA_W-1:0] pick_wdata;

    scs_bank_pick #(
      .NUM_LANES (NUM_LANES),
      .ROW_W     (ROW_W),
      .DATA_W    (DATA_W)
    ) u_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit[b]),
      .row_i   (row_q),
      .we_i    (we_q),
      .wdata_i (wdata_q),
      .serve_o (bank_serve[b]),
      .row_o   (pick_row),
      .wr_o    (pick_wr),
      .wdata_o (pick_wdata)
    );

    scs_bank_ram #(
      .ROW_W  (ROW_W),
      .DATA_W (DATA_W)
    ) u_ram (
      .clk_i   (clk_i),
      .we_i    (pick_wr && busy_q),
      .row_i   (pick_row),
      .wdata_i (pick_wdata),
      .rdata_o (bank_rd[b])
    );
  end

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      served[l]  = bank_serve[bank_q[l]][l];
      lane_rd[l] = bank_rd[bank_q[l]];
    end
  end

  assign pend_nxt = pend_q & ~served;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      bank_q   <= '0;
      row_q    <= '0;
      we_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= '0;
      degree_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        pend_q  <= lane_valid_i;
        bank_q  <= bank_d;
        row_q   <= row_d;
        we_q    <= lane_we_i;
        wdata_q <= wdata_d;
        rdata_q <= '0;
        pass_q  <= '0;
        if (lane_valid_i == '0) begin
          done_q   <= 1'b1;
          degree_q <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        pend_q <= pend_nxt;
        pass_q <= pass_q + DEG_W'(1);
        for (int l = 0; l < NUM_LANES; l++) begin
          if (served[l]) rdata_q[l] <= lane_rd[l];
        end
        if (pend_nxt == '0) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          degree_q <= pass_q + DEG_W'(1);
        end
      end
    end
  end

  assign done_o   = done_q;
  assign degree_o = degree_q;
  assign rdata_o  = rdata_q;

  AST_PASS_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (served != '0)); // R3
  AST_DEGREE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (degree_o <= DEG_W'(NUM_LANES))); // R3
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && lane_valid_i != '0) |=> !req_ready_o); // R4
  AST_EMPTY_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && lane_valid_i == '0) |=> (done_o && degree_o == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fire) |=> !done_o); // R10
  AST_READ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !fire) |=> $stable(rdata_o)); // R6
endmodule

// File: tb/bank_conflict_serializer_tb_top.sv
`timescale 1ns/1ps
module bank_conflict_serializer_tb_top;
  import scs_pkg::*;
  localparam int L     = SCS_LANES;
  localparam int NB    = SCS_BANKS;
  localparam int RW    = SCS_ROW_W;
  localparam int DW    = SCS_DATA_W;
  localparam int BW    = $clog2(NB);
  localparam int AW    = 2 + BW + RW;
  localparam int DGW   = $clog2(L + 1);
  localparam int WORDS = NB << RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [L-1:0] lane_valid = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L-1:0] lane_we = '0;
  logic [L*DW-1:0] lane_wdata = '0;
  logic done;
  logic [DGW-1:0] degree;
  logic [L*DW-1:0] rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DW-1:0] model [WORDS];
  logic [AW-1:0] s_addr [L];
  logic [DW-1:0] s_wd [L];
  logic [L-1:0]  s_v, s_we;

  always #10 clk = ~clk;

  bank_conflict_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .lane_valid_i(lane_valid), .lane_addr_i(lane_addr), .lane_we_i(lane_we),
    .lane_wdata_i(lane_wdata), .done_o(done), .degree_o(degree), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // R1: bank = addr[6:2], row = addr[12:7]
  function automatic int exp_degree();
    int mx = 0;
    for (int b = 0; b < NB; b++) begin
      int cnt = 0;
      for (int l = 0; l < L; l++) begin
        bit seen = 0;
        if (!s_v[l] || int'(s_addr[l][2 +: BW]) != b) continue;
        for (int j = 0; j < l; j++)
          if (s_v[j] && s_addr[j][AW-1:2] == s_addr[l][AW-1:2]) seen = 1;
        if (!seen) cnt++;
      end
      if (cnt > mx) mx = cnt;
    end
    return mx;
  endfunction

  function automatic int word_of(input int l);
    return int'(s_addr[l][AW-1:2]);
  endfunction

  // called at a negedge with ready expected high; returns at the negedge of done
  task automatic run_req(input bit chk_rd, input string tag);
    int d, n;
    bit ready_low_ok;
    logic [DW-1:0] exp_rd [L];
    d = exp_degree();
    for (int l = 0; l < L; l++) exp_rd[l] = s_v[l] ? model[word_of(l)] : '0;
    for (int l = 0; l < L; l++) if (s_v[l] && s_we[l]) model[word_of(l)] = s_wd[l]; // R7 highest wins
    for (int l = 0; l < L; l++) begin
      lane_addr[l*AW +: AW]  = s_addr[l];
      lane_wdata[l*DW +: DW] = s_wd[l];
    end
    lane_valid = s_v;
    lane_we    = s_we;
    req_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    ready_low_ok = 1;
    while (!done && n < 64) begin
      if (req_ready) ready_low_ok = 0;
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1 && n == d, {tag, " R3 cycles to done"}, n, d);
    chk(int'(degree) == d, {tag, " R3 degree"}, degree, d);
    chk(req_ready == 1'b1, {tag, " R4 ready in done cycle"}, req_ready, 1);
    if (d > 1) chk(ready_low_ok, {tag, " R4 ready low while busy"}, ready_low_ok, 1);
    if (chk_rd) begin
      int bad = -1;
      for (int l = 0; l < L; l++) if (rdata[l*DW +: DW] !== exp_rd[l] && bad < 0) bad = l;
      if (bad < 0) chk(1, "", 0, 0);
      else chk(0, $sformatf("%s R6 rdata lane %0d", tag, bad), rdata[bad*DW +: DW], exp_rd[bad]);
    end
  endtask

  task automatic set_stride(input int base, input int stride, input bit we);
    for (int l = 0; l < L; l++) begin
      s_addr[l] = AW'(((base + l * stride) % WORDS) * 4);
      s_wd[l]   = $urandom;
    end
    s_v  = '1;
    s_we = we ? '1 : '0;
  endtask

  task automatic read_word(input int w, input string tag);
    for (int l = 0; l < L; l++) begin
      s_addr[l] = AW'(w * 4);
      s_wd[l]   = '0;
    end
    s_v = '1;
    s_we = '0;
    run_req(1, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(degree == '0, "R9 degree after reset", degree, 0);
    chk(rdata == '0, "R9 rdata after reset", rdata == '0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // fill memory, stride 1 writes
    for (int r = 0; r < (1 << RW); r++) begin
      set_stride(r * NB, 1, 1);
      run_req(0, "R5 init fill");
    end

    // R5 strides
    set_stride(5, 1, 0);   run_req(1, "R5 stride1");
    set_stride(0, 2, 0);   run_req(1, "R5 stride2");
    set_stride(3, 4, 0);   run_req(1, "R5 stride4");
    set_stride(7, 32, 0);  run_req(1, "R5 stride32");

    // R1 byte offsets ignored
    set_stride(40, 1, 0);
    for (int l = 0; l < L; l++) s_addr[l][1:0] = 2'(l);
    run_req(1, "R1 byte offset");

    // R2 broadcast, then two words in one bank
    read_word(77, "R2 broadcast");
    for (int l = 0; l < L; l++) s_addr[l] = AW'(((l < 16) ? 9 : 9 + NB) * 4);
    run_req(1, "R2 two groups");

    // R7 write conflict, lane 31 inactive
    for (int l = 0; l < L; l++) begin
      s_addr[l] = AW'(100 * 4);
      s_wd[l]   = 32'hA000_0000 + l;
    end
    s_v = '1; s_v[31] = 1'b0; s_we = '1;
    run_req(1, "R7 same-word writers");
    read_word(100, "R7 readback highest lane");

    // R8 empty request with stray writes, then readback
    for (int l = 0; l < L; l++) begin
      s_addr[l] = AW'(200 * 4);
      s_wd[l]   = 32'hDEAD_0000 + l;
    end
    s_v = '0; s_we = '1;
    run_req(1, "R8 empty request");
    read_word(200, "R8 inactive no write");

    // R6 read and write same word in one pass
    set_stride(300, 1, 0);
    s_addr[1] = s_addr[0]; s_we[1] = 1'b1; s_wd[1] = 32'h1234_5678;
    run_req(1, "R6 read old on write");
    read_word(300, "R6 readback");

    // R10 pulse ends when idle; R6 data held
    begin
      logic [L*DW-1:0] held;
      held = rdata;
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", done, 0);
      chk(rdata == held, "R6 rdata held while idle", rdata == held, 1);
    end

    // random mix
    for (int t = 0; t < 400; t++) begin
      int mode = int'($urandom_range(0, 3));
      int base = int'($urandom_range(0, WORDS - 1));
      int stride = 1 << $urandom_range(0, 5);
      for (int l = 0; l < L; l++) begin
        int w;
        case (mode)
          0: w = (base + l * stride) % WORDS;
          1: w = (base + int'($urandom_range(0, 3)) * NB) % WORDS;
          2: w = int'($urandom_range(0, WORDS - 1));
          default: w = (base + l * 3) % WORDS;
        endcase
        s_addr[l] = AW'(w * 4 + int'($urandom_range(0, 3)));
        s_wd[l]   = $urandom;
      end
      s_v  = ($urandom_range(0, 7) == 0) ? L'($urandom) & L'($urandom) : L'($urandom) | L'($urandom);
      s_we = L'($urandom) & L'($urandom);
      run_req(1, "R1 R3 random");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired R3 act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule